// File: doc/BRIEF.md
# Genlock Reference Nibble Inserter

This block merges an 8-bit composite video pixel stream with a short genlock reference packet. The packet carries a field identifier plus a 24-bit subcarrier frequency word and a 24-bit subcarrier phase word. It runs on the 2x pixel clock. Pixels are captured on a half-rate enable and held on the bus. The packet is sent one nibble per clock on the low four bus lines during the horizontal sync tip, and the high four lines are held at zero.

A downstream encoder or frame store reads the packet to lock its own subcarrier to the incoming video. The field identifier depends on the selected standard. With 525-line timing it counts four fields. With 625-line timing it counts eight fields and also flags the lines on which the V component is inverted. Two controls act on the data: one turns the packet off entirely, and the other blanks the video to zero while line lock is lost but keeps the packet running.

Top module: `gri_inserter`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears the block: `bus_out` is 0x00 and `pkt_active` is low after it.
- R2: The packet begins when `hs_start` is sampled high at clock edge E0 while no packet is pending and `pkt_disable` is low. Nibble k (k = 0..12) is on the bus after edge E0+START_OFFSET+k. `pkt_active` is high for exactly those 13 cycles.
- R3: Within the packet, bits 3..0 carry the field nibble first. Next come the six frequency nibbles, bits 23:20 first and bits 3:0 last. The six phase nibbles follow in the same order. Bits 7..4 are zero for the whole packet.
- R4: With `std_pal` low, field nibble bits 2..0 are {0, field_cnt[1:0]}, where field_cnt is the 0-based field index. Bit 0 is therefore low in the odd fields 1 and 3, and field_cnt[2] has no effect.
- R5: With `std_pal` high, field nibble bits 2..0 equal field_cnt[2:0], so they count 000 to 111 over fields 1 to 8.
- R6: Field nibble bit 3 is 1 when `std_pal` is low. When `std_pal` is high it is the inverse of `v_invert`, so it is 0 on V-inverted lines.
- R7: The frequency word, phase word and field inputs are sampled at the edge that puts nibble 0 on the bus. Changes to them during the packet do not alter the packet.
- R8: An `hs_start` pulse sampled while `pkt_disable` is high starts no packet. The bus keeps showing video.
- R9: An `hs_start` pulse sampled while a packet is pending or being sent is ignored. No second packet follows.
- R10: Outside the packet, `bus_out` shows the last `pix_in` value sampled at an edge where `pix_en` was high. That value is held while `pix_en` is low.
- R11: While `suppress_en` and `unlocked` are both high, `bus_out` is 0x00 outside the packet. The packet itself is sent unchanged. When either control drops, the held pixel reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2x pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Half-rate pixel enable |
| pix_in | input | 8 | Composite pixel data |
| hs_start | input | 1 | One-cycle pulse at the start of horizontal sync |
| field_cnt | input | 3 | 0-based field index from the field counter |
| std_pal | input | 1 | Standard select: 1 = 625-line, 0 = 525-line |
| v_invert | input | 1 | High on V-inverted lines (625-line only) |
| freq_word | input | 24 | Subcarrier frequency word |
| phase_word | input | 24 | Subcarrier phase word |
| pkt_disable | input | 1 | High turns off packet insertion |
| suppress_en | input | 1 | Enables video blanking while lock is lost |
| unlocked | input | 1 | High while line lock is lost |
| bus_out | output | 8 | Multiplexed video / packet bus |
| pkt_active | output | 1 | High while a packet nibble is on the bus |

## Verification
A sequencer left in the wrong state shows up as a bad `pkt_active` run within one line. The run may start a cycle early or late, be shorter or longer than 13 cycles, or be repeated, and each case is visible within START_OFFSET+13 cycles of the sync pulse. A packet register that loads at the wrong time or shifts wrongly puts an incorrect nibble on the bus in the very cycle it is used. Sweeping every field index and standard and inversion combination, with a distinct word pattern on each line, exposes any swapped, stale or misordered nibble in the packet in which it occurs. A wrong pixel hold register or wrong blanking gate changes the bus on the cycle after the enable or control edge.

// File: rtl/gri_pkg.sv
// Package: shared constants and types for the genlock reference inserter.
// Assumes nibble-serial transfer of two equal-width words plus one field nibble.
package gri_pkg;
    localparam int NIB_W   = 4;
    localparam int FIELD_W = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_SEND = 2'd2
    } gri_seq_e;
endpackage

// File: rtl/gri_field_encoder.sv
// Module: gri_field_encoder
// Builds the field identifier nibble from the field index and standard.
// Assumes field_cnt is a 0-based index; 525-line mode uses only its low two bits.
module gri_field_encoder
    import gri_pkg::*;
(
    input  logic [FIELD_W-1:0] field_cnt,
    input  logic               std_pal,
    input  logic               v_invert,
    output logic [NIB_W-1:0]   field_nib
);
    logic [FIELD_W-1:0] id_bits;
    logic               burst_flag;

    // Select the field count encoding for the chosen standard.
    always_comb begin
        if (std_pal) begin
            id_bits = field_cnt;
        end else begin
            id_bits = {1'b0, field_cnt[1:0]};
        end
    end

    // Flag bit: set on 525-line, cleared on V-inverted 625-line lines.
    always_comb begin
        burst_flag = std_pal ? ~v_invert : 1'b1;
    end

    assign field_nib = {burst_flag, id_bits};
endmodule

// File: rtl/gri_sequencer.sv
// Module: gri_sequencer
// Times the packet: waits START_OFFSET edges after the sync pulse, then holds the
// send state for PKT_LEN cycles. Assumes START_OFFSET >= 1. Sync pulses seen
// outside the idle state are ignored.
module gri_sequencer
    import gri_pkg::*;
#(
    parameter int START_OFFSET = 4,
    parameter int PKT_LEN      = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_start,
    input  logic pkt_disable,
    output logic load,
    output logic sending
);
    localparam int SPAN  = (PKT_LEN > START_OFFSET) ? PKT_LEN : START_OFFSET;
    localparam int CNT_W = $clog2(SPAN) + 1;

    gri_seq_e         state_q;
    logic [CNT_W-1:0] cnt_q;

    // State and countdown for the wait and send phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (hs_start && !pkt_disable) begin
                        state_q <= SEQ_WAIT;
                        cnt_q   <= CNT_W'(START_OFFSET - 1);
                    end
                end
                SEQ_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_SEND;
                        cnt_q   <= CNT_W'(PKT_LEN - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SEQ_SEND: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Capture strobe at the edge that enters the send state.
    assign load    = (state_q == SEQ_WAIT) && (cnt_q == '0);
    assign sending = (state_q == SEQ_SEND);
endmodule

// File: rtl/gri_packet_shifter.sv
// Module: gri_packet_shifter
// Captures the field nibble and both words in one register at the load strobe,
// then shifts them out one nibble per clock, most significant nibble first.
module gri_packet_shifter
    import gri_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic [NIB_W-1:0]   field_nib,
    input  logic [WORD_W-1:0]  freq_word,
    input  logic [WORD_W-1:0]  phase_word,
    output logic [NIB_W-1:0]   nib_out
);
    localparam int PKT_BITS = NIB_W + 2 * WORD_W;

    logic [PKT_BITS-1:0] sr_q;

    // Load a coherent snapshot, or advance by one nibble while sending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= {field_nib, freq_word, phase_word};
        end else if (shift) begin
            sr_q <= {sr_q[PKT_BITS-NIB_W-1:0], {NIB_W{1'b0}}};
        end
    end

    assign nib_out = sr_q[PKT_BITS-1 -: NIB_W];
endmodule

// File: rtl/gri_pixel_path.sv
// Module: gri_pixel_path
// Holds the latest enabled pixel and blanks it while suppression is active.
module gri_pixel_path #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             blank,
    output logic [PIX_W-1:0] pix_out
);
    logic [PIX_W-1:0] pix_q;

    // Sample the pixel stream on the half-rate enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else if (pix_en) begin
            pix_q <= pix_in;
        end
    end

    assign pix_out = blank ? '0 : pix_q;
endmodule

// File: rtl/gri_inserter.sv
// Module: gri_inserter (top)
// Places a genlock reference packet on the low nibble of the video bus during
// sync, and video pixels elsewhere. Assumes hs_start is a single-cycle pulse.
module gri_inserter
    import gri_pkg::*;
#(
    parameter int PIX_W        = 8,
    parameter int WORD_W       = 24,
    parameter int START_OFFSET = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_en,
    input  logic [PIX_W-1:0]    pix_in,
    input  logic                hs_start,
    input  logic [2:0]          field_cnt,
    input  logic                std_pal,
    input  logic                v_invert,
    input  logic [WORD_W-1:0]   freq_word,
    input  logic [WORD_W-1:0]   phase_word,
    input  logic                pkt_disable,
    input  logic                suppress_en,
    input  logic                unlocked,
    output logic [PIX_W-1:0]    bus_out,
    output logic                pkt_active
);
    localparam int WORD_NIBS = WORD_W / NIB_W;
    localparam int PKT_LEN   = 1 + 2 * WORD_NIBS;

    logic [NIB_W-1:0] field_nib;
    logic [NIB_W-1:0] pkt_nib;
    logic [PIX_W-1:0] pix_val;
    logic             load;
    logic             sending;
    logic             blank;

    gri_field_encoder u_field (
        .field_cnt (field_cnt),
        .std_pal   (std_pal),
        .v_invert  (v_invert),
        .field_nib (field_nib)
    );

    gri_sequencer #(
        .START_OFFSET (START_OFFSET),
        .PKT_LEN      (PKT_LEN)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_start    (hs_start),
        .pkt_disable (pkt_disable),
        .load        (load),
        .sending     (sending)
    );

    gri_packet_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .shift      (sending),
        .field_nib  (field_nib),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .nib_out    (pkt_nib)
    );

    assign blank = suppress_en & unlocked;

    gri_pixel_path #(
        .PIX_W (PIX_W)
    ) u_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_en  (pix_en),
        .pix_in  (pix_in),
        .blank   (blank),
        .pix_out (pix_val)
    );

    // Bus select: packet nibble with zeroed upper lines, or the pixel.
    always_comb begin
        if (sending) begin
            bus_out = {{(PIX_W-NIB_W){1'b0}}, pkt_nib};
        end else begin
            bus_out = pix_val;
        end
    end

    assign pkt_active = sending;
endmodule

// File: rtl/gri_inserter_checker.sv
// Module: gri_inserter_checker
// Port-level properties of the inserter, attached with bind below.
module gri_inserter_checker #(
    parameter int PIX_W   = 8,
    parameter int PKT_LEN = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic             suppress_en,
    input logic             unlocked,
    input logic             pkt_active,
    input logic [PIX_W-1:0] bus_out
);
    localparam int RUN_W = $clog2(PKT_LEN + 2) + 1;

    logic [RUN_W-1:0] run_q;

    // Count consecutive cycles with the packet flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pkt_active) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R3: upper bus lines stay zero during the packet.
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_active |-> (bus_out[PIX_W-1:4] == '0));

    // R2: a packet ends after exactly PKT_LEN cycles.
    p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pkt_active) |-> (run_q == RUN_W'(PKT_LEN)));

    // R2: a packet never exceeds PKT_LEN cycles.
    p_run_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(PKT_LEN));

    // R11: blanked video reads zero outside the packet.
    p_blank_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_active && suppress_en && unlocked) |-> (bus_out == '0));

    // R10: with no enable and steady controls the video is held.
    p_pix_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pix_en) && !pkt_active && !$past(pkt_active)
         && !(suppress_en && unlocked) && !($past(suppress_en) && $past(unlocked)))
        |-> $stable(bus_out));
endmodule

bind gri_inserter gri_inserter_checker #(
    .PIX_W   (PIX_W),
    .PKT_LEN (PKT_LEN)
) u_gri_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .suppress_en (suppress_en),
    .unlocked    (unlocked),
    .pkt_active  (pkt_active),
    .bus_out     (bus_out)
);

// File: tb/gri_inserter_bench.sv
module gri_inserter_bench;
    localparam int PERIOD  = 10;
    localparam int OFF     = 4;
    localparam int PKT_LEN = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic [7:0]  pix_in = '0;
    logic        hs_start = 1'b0;
    logic [2:0]  field_cnt = '0;
    logic        std_pal = 1'b0;
    logic        v_invert = 1'b0;
    logic [23:0] freq_word = '0;
    logic [23:0] phase_word = '0;
    logic        pkt_disable = 1'b0;
    logic        suppress_en = 1'b0;
    logic        unlocked = 1'b0;
    logic [7:0]  bus_out;
    logic        pkt_active;

    int errors = 0;
    int checks = 0;

    always #(PERIOD/2) clk = ~clk;

    gri_inserter #(.PIX_W(8), .WORD_W(24), .START_OFFSET(OFF)) u_gri_inserter (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_in(pix_in),
        .hs_start(hs_start), .field_cnt(field_cnt), .std_pal(std_pal),
        .v_invert(v_invert), .freq_word(freq_word), .phase_word(phase_word),
        .pkt_disable(pkt_disable), .suppress_en(suppress_en), .unlocked(unlocked),
        .bus_out(bus_out), .pkt_active(pkt_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_field(input logic pal, input logic [2:0] fc, input logic vi);
        logic b3;
        logic [2:0] id;
        b3 = pal ? ~vi : 1'b1;
        id = pal ? fc : {1'b0, fc[1:0]};
        return {b3, id};
    endfunction

    function automatic logic [3:0] exp_nib(input int k, input logic [3:0] fn,
                                           input logic [23:0] fw, input logic [23:0] pw);
        if (k == 0) return fn;
        else if (k <= 6) return fw[4*(6-k) +: 4];
        else return pw[4*(12-k) +: 4];
    endfunction

    // Send one sync pulse and check the packet nibble by nibble (R2..R7, R9, R11).
    task automatic run_packet(input int iter, input logic pal, input logic [2:0] fc,
                              input logic vi, input logic kill, input logic extra_hs);
        logic [23:0] fw;
        logic [23:0] pw;
        logic [3:0]  fn;
        fw = 24'h13579B ^ (24'(iter) * 24'h0F1E2D);
        pw = 24'hECA864 + (24'(iter) * 24'h102031);
        fn = exp_field(pal, fc, vi);
        @(negedge clk);
        std_pal = pal; field_cnt = fc; v_invert = vi;
        freq_word = fw; phase_word = pw;
        suppress_en = kill; unlocked = kill;
        hs_start = 1'b1;
        @(negedge clk);
        hs_start = 1'b0;
        for (int j = 1; j < OFF; j++) begin
            @(negedge clk);
            check("R2 wait", {31'd0, pkt_active}, 32'd0);
        end
        for (int k = 0; k < PKT_LEN; k++) begin
            @(negedge clk);
            check("R2 active", {31'd0, pkt_active}, 32'd1);
            check(k == 0 ? "R3 R4 R5 R6 field" : "R3 R7 R11 nibble",
                  {24'd0, bus_out}, {28'd0, exp_nib(k, fn, fw, pw)});
            // R7: disturb the inputs once the packet is latched.
            freq_word = ~fw; phase_word = ~pw;
            field_cnt = ~fc; v_invert = ~vi; std_pal = ~pal;
            hs_start = extra_hs && (k == 5);
        end
        @(negedge clk);
        hs_start = 1'b0;
        check("R2 end", {31'd0, pkt_active}, 32'd0);
        if (extra_hs) begin
            for (int j = 0; j < OFF + PKT_LEN; j++) begin
                @(negedge clk);
                check("R9 ignored", {31'd0, pkt_active}, 32'd0);
            end
        end
        suppress_en = 1'b0; unlocked = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] v;
        // R1: reset state.
        pix_en = 1'b1; pix_in = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 bus", {24'd0, bus_out}, 32'd0);
        check("R1 active", {31'd0, pkt_active}, 32'd0);
        rst_n = 1'b1; pix_en = 1'b0;
        @(negedge clk);
        check("R1 after", {24'd0, bus_out}, 32'd0);

        // R10 and R11: pixel capture, hold and blanking.
        for (int i = 0; i < 16; i++) begin
            v = 8'(i * 37 + 5);
            pix_in = v; pix_en = 1'b1;
            @(negedge clk);
            check("R10 load", {24'd0, bus_out}, {24'd0, v});
            pix_in = ~v; pix_en = 1'b0;
            @(negedge clk);
            check("R10 hold", {24'd0, bus_out}, {24'd0, v});
            suppress_en = i[0]; unlocked = 1'b1;
            @(negedge clk);
            check("R11 blank", {24'd0, bus_out}, i[0] ? 32'd0 : {24'd0, v});
            unlocked = 1'b0;
            @(negedge clk);
            check("R11 restore", {24'd0, bus_out}, {24'd0, v});
            suppress_en = 1'b0;
        end

        // Sweep standard, field index and inversion.
        for (int it = 0; it < 32; it++) begin
            run_packet(it, it[4], it[3:1], it[0], (it % 3) == 0, (it % 5) == 2);
        end

        // R8: disabled packet.
        pix_in = 8'hA5; pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0; pkt_disable = 1'b1; hs_start = 1'b1;
        @(negedge clk);
        hs_start = 1'b0;
        for (int j = 0; j < OFF + PKT_LEN + 2; j++) begin
            @(negedge clk);
            check("R8 no packet", {31'd0, pkt_active}, 32'd0);
            check("R8 video", {24'd0, bus_out}, 32'h0000_00A5);
        end
        pkt_disable = 1'b0;
        run_packet(40, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule